// File: doc/BRIEF.md
# Five-Stage Pipelined Integer Core

This block is a small load-store processor core split into five pipeline stages: fetch, decode with register read, execute, memory access and register writeback. It has eight 32-bit general registers, an instruction store and a data store. Both stores are word-addressed, held inside the block, and indexed by the low address bits. The instruction set covers add, nand, load word, store word and branch-if-equal. Any other opcode does nothing.

A separate hazard unit keeps the pipeline correct. Results of arithmetic instructions are forwarded into the execute stage from the two stages after it. A load whose result is needed by the very next instruction holds the front of the pipeline for one cycle. Branches are predicted not taken and resolve in the memory stage. On a taken branch, the three younger instructions are turned into no-ops and fetch is redirected. The register file is written ahead of the read, so decode sees a value that writeback delivers in the same cycle.

A program and its initial data are written through a load port while reset is held. The core runs when reset is released. Debug outputs expose the fetch address, one selected register and one selected data word.

Top module: `pipe_core`

## Requirements
- R1: While reset is held and on the first cycle after it, the fetch address is 0. All eight registers read 0, and no register or data word changes until the first instruction reaches its final stage.
- R2: An instruction word holds the opcode in bits 26:24 (0 no-op, 1 add, 2 nand, 3 load, 4 store, 5 branch-if-equal), the first source or base register in bits 23:21, the second source or data register in bits 17:15, the destination register in bits 2:0, and a 15-bit offset in bits 14:0 that is sign-extended. Opcodes 6 and 7 change no register and no data word.
- R3: Add writes the sum of the two source registers to the destination register. Nand writes the bitwise inverse of their AND.
- R4: Load writes data word [(base + offset) mod data depth] into the register named by bits 17:15. Store writes that register into the same data word.
- R5: Branch-if-equal continues at PC+1+offset when its two registers are equal, and at PC+1 otherwise. For a taken branch at address 0 the fetch address reads 1, 2, 3, then the target on the four cycles after reset. None of the three instructions fetched after a taken branch has any effect.
- R6: An instruction that reads a register written by one of the two arithmetic instructions just before it gets the new value with no lost cycle; the fetch address advances by one every cycle. When several earlier instructions write the same register, the youngest of them supplies the value.
- R7: An instruction that reads the register loaded by the instruction just before it stalls for exactly one cycle. For a load at address 0 followed by such a consumer, the fetch address reads 1, 2, 2, 3. The consumer gets the loaded value, whether it uses it as an operand or as store data.
- R8: A value being written back is visible to an instruction decoding in the same cycle, three instructions later, with no stall.
- R9: Writes on the load port take effect only while reset is held. Port writes made while the core runs change nothing.
- R10: The register debug output shows the selected register, the data debug output shows the selected data word, and the fetch-address output shows the address being fetched. A program that ends in a branch to itself leaves the fetch address within three words after that branch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high; enables the load port |
| pgmWe | input | 1 | Load-port write strobe (effective only in reset) |
| pgmSel | input | 1 | Load-port target: 0 instruction store, 1 data store |
| pgmAddr | input | PAW (6) | Load-port word address |
| pgmData | input | XLEN (32) | Load-port write data |
| dbgRegSel | input | 3 | Register selected for observation |
| dbgRegVal | output | XLEN (32) | Contents of the selected register |
| dbgMemAddr | input | DW (6) | Data word selected for observation |
| dbgMemVal | output | XLEN (32) | Contents of the selected data word |
| dbgPc | output | IW (6) | Current fetch address |

## Verification
Directed programs separate the hazard paths. A producer chain at distances one, two and three exercises the execute-stage forwarding, the nearest-producer priority and the same-cycle writeback read. A load followed by a consumer, and by a store of the loaded value, exercises the stall path. Taken and not-taken branches with register-writing instructions in their shadow show whether squashing and redirection happen on the right cycle; fetch-address sequences give the cycle-exact view of stalls and redirects. Random programs with a small register pool mix all of these at random distances, and final register and data contents are compared against an instruction-by-instruction model.

// File: rtl/pipe_pkg.sv
package pipe_pkg;

  localparam int INSTR_W   = 32;
  localparam int OPC_LSB   = 24;
  localparam int OPC_W     = 3;
  localparam int RA_LSB    = 21;
  localparam int RB_LSB    = 15;
  localparam int RD_LSB    = 0;
  localparam int OFF_W     = 15;
  localparam int RF_W      = 3;
  localparam int RF_COUNT  = 1 << RF_W;

  typedef enum logic [OPC_W-1:0] {
    OP_NOP  = 3'd0,
    OP_ADD  = 3'd1,
    OP_NAND = 3'd2,
    OP_LW   = 3'd3,
    OP_SW   = 3'd4,
    OP_BEQ  = 3'd5
  } opcode_e;

  typedef enum logic [1:0] {
    SRC_REG = 2'd0,
    SRC_MEM = 2'd1,
    SRC_WB  = 2'd2
  } fwd_e;

  // strobes from the hazard unit to the datapath
  typedef struct packed {
    logic stall;
    logic flush;
    fwd_e fwdA;
    fwd_e fwdB;
  } ctrl_t;

  function automatic opcode_e decodeOp(input logic [OPC_W-1:0] raw);
    case (raw)
      3'd1:    return OP_ADD;
      3'd2:    return OP_NAND;
      3'd3:    return OP_LW;
      3'd4:    return OP_SW;
      3'd5:    return OP_BEQ;
      default: return OP_NOP;
    endcase
  endfunction

  function automatic logic writesReg(input opcode_e op);
    return (op == OP_ADD) || (op == OP_NAND) || (op == OP_LW);
  endfunction

  function automatic logic readsA(input opcode_e op);
    return op != OP_NOP;
  endfunction

  function automatic logic readsB(input opcode_e op);
    return (op == OP_ADD) || (op == OP_NAND) || (op == OP_SW) || (op == OP_BEQ);
  endfunction

endpackage

// File: rtl/pipe_regfile.sv
module pipe_regfile
  import pipe_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            we,
  input  logic [RF_W-1:0] wAddr,
  input  logic [XLEN-1:0] wData,
  input  logic [RF_W-1:0] rAddrA,
  input  logic [RF_W-1:0] rAddrB,
  output logic [XLEN-1:0] rDataA,
  output logic [XLEN-1:0] rDataB,
  input  logic [RF_W-1:0] dbgAddr,
  output logic [XLEN-1:0] dbgData
);

  logic [XLEN-1:0] regs [RF_COUNT];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < RF_COUNT; i++) regs[i] <= '0;
    end else if (we) begin
      regs[wAddr] <= wData;
    end
  end

  // write-before-read: a value being written back is seen by decode now
  always_comb begin
    rDataA = (we && wAddr == rAddrA) ? wData : regs[rAddrA];
    rDataB = (we && wAddr == rAddrB) ? wData : regs[rAddrB];
  end

  assign dbgData = regs[dbgAddr];

endmodule

// File: rtl/pipe_hazard.sv
module pipe_hazard
  import pipe_pkg::*;
(
  input  logic [RF_W-1:0] idRegA,
  input  logic [RF_W-1:0] idRegB,
  input  logic            idUseA,
  input  logic            idUseB,
  input  logic            exLoad,
  input  logic [RF_W-1:0] exDest,
  input  logic [RF_W-1:0] exRegA,
  input  logic [RF_W-1:0] exRegB,
  input  logic            memFwd,
  input  logic [RF_W-1:0] memDest,
  input  logic            wbWrites,
  input  logic [RF_W-1:0] wbDest,
  input  logic            brTaken,
  output ctrl_t           ctrl
);

  function automatic fwd_e pickSrc(input logic [RF_W-1:0] src,
                                   input logic memOk, input logic [RF_W-1:0] memRd,
                                   input logic wbOk,  input logic [RF_W-1:0] wbRd);
    if (memOk && memRd == src) return SRC_MEM;   // youngest producer first
    if (wbOk && wbRd == src)   return SRC_WB;
    return SRC_REG;
  endfunction

  logic loadUse;

  always_comb begin
    loadUse = exLoad && ((idUseA && exDest == idRegA) || (idUseB && exDest == idRegB));
    ctrl.flush = brTaken;
    ctrl.stall = loadUse && !brTaken;
    ctrl.fwdA  = pickSrc(exRegA, memFwd, memDest, wbWrites, wbDest);
    ctrl.fwdB  = pickSrc(exRegB, memFwd, memDest, wbWrites, wbDest);
  end

endmodule

// File: rtl/pipe_datapath.sv
module pipe_datapath
  import pipe_pkg::*;
#(
  parameter int XLEN       = 32,
  parameter int IMEM_DEPTH = 64,
  parameter int DMEM_DEPTH = 64,
  parameter int IW         = 6,
  parameter int DW         = 6,
  parameter int PAW        = 6
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            pgmWe,
  input  logic            pgmSel,
  input  logic [PAW-1:0]  pgmAddr,
  input  logic [XLEN-1:0] pgmData,
  input  ctrl_t           ctrl,
  output logic [RF_W-1:0] idRegA,
  output logic [RF_W-1:0] idRegB,
  output logic            idUseA,
  output logic            idUseB,
  output logic            exLoad,
  output logic [RF_W-1:0] exDest,
  output logic [RF_W-1:0] exRegA,
  output logic [RF_W-1:0] exRegB,
  output logic            memFwd,
  output logic [RF_W-1:0] memDest,
  output logic            wbWrites,
  output logic [RF_W-1:0] wbDest,
  output logic            brTaken,
  input  logic [RF_W-1:0] dbgRegSel,
  output logic [XLEN-1:0] dbgRegVal,
  input  logic [DW-1:0]   dbgMemAddr,
  output logic [XLEN-1:0] dbgMemVal,
  output logic [IW-1:0]   dbgPc
);

  logic [INSTR_W-1:0] imem [IMEM_DEPTH];
  logic [XLEN-1:0]    dmem [DMEM_DEPTH];

  // fetch
  logic [IW-1:0] pc, pcPlus1;
  // fetch/decode register
  logic [INSTR_W-1:0] fdInstr;
  logic [IW-1:0]      fdPc1;
  // decode/execute register
  opcode_e         deOp;
  logic [RF_W-1:0] deRa, deRb, deRd;
  logic [XLEN-1:0] deValA, deValB, deOff;
  logic [IW-1:0]   dePc1;
  // execute/memory register
  opcode_e         emOp;
  logic [RF_W-1:0] emRd;
  logic [XLEN-1:0] emAlu, emStore;
  logic            emTaken;
  logic [IW-1:0]   emTarget;
  // memory/writeback register
  opcode_e         mwOp;
  logic [RF_W-1:0] mwRd;
  logic [XLEN-1:0] mwVal;

  // ---------------- program load port ----------------
  always_ff @(posedge clk) begin
    if (rst && pgmWe && !pgmSel) imem[pgmAddr[IW-1:0]] <= pgmData[INSTR_W-1:0];
  end

  // ---------------- decode ----------------
  opcode_e         fdOp;
  logic [RF_W-1:0] fdRa, fdRb, fdRd;
  logic [XLEN-1:0] fdOff, rfA, rfB;

  always_comb begin
    fdOp  = decodeOp(fdInstr[OPC_LSB +: OPC_W]);
    fdRa  = fdInstr[RA_LSB +: RF_W];
    fdRb  = fdInstr[RB_LSB +: RF_W];
    fdRd  = (fdOp == OP_LW) ? fdRb : fdInstr[RD_LSB +: RF_W];
    fdOff = {{(XLEN-OFF_W){fdInstr[OFF_W-1]}}, fdInstr[OFF_W-1:0]};
  end

  logic wbWe;
  assign wbWe = writesReg(mwOp);

  pipe_regfile #(.XLEN(XLEN)) u_rf (
    .clk     (clk),
    .rst     (rst),
    .we      (wbWe),
    .wAddr   (mwRd),
    .wData   (mwVal),
    .rAddrA  (fdRa),
    .rAddrB  (fdRb),
    .rDataA  (rfA),
    .rDataB  (rfB),
    .dbgAddr (dbgRegSel),
    .dbgData (dbgRegVal)
  );

  // ---------------- execute ----------------
  logic [XLEN-1:0] opA, opB, aluRes;
  logic            exTaken;
  logic [IW-1:0]   exTarget;

  function automatic logic [XLEN-1:0] pickOperand(input fwd_e sel, input logic [XLEN-1:0] regVal,
                                                  input logic [XLEN-1:0] memVal,
                                                  input logic [XLEN-1:0] wbVal);
    case (sel)
      SRC_MEM: return memVal;
      SRC_WB:  return wbVal;
      default: return regVal;
    endcase
  endfunction

  always_comb begin
    opA = pickOperand(ctrl.fwdA, deValA, emAlu, mwVal);
    opB = pickOperand(ctrl.fwdB, deValB, emAlu, mwVal);
    case (deOp)
      OP_ADD:       aluRes = opA + opB;
      OP_NAND:      aluRes = ~(opA & opB);
      OP_LW, OP_SW: aluRes = opA + deOff;
      default:      aluRes = '0;
    endcase
    exTaken  = (deOp == OP_BEQ) && (opA == opB);
    exTarget = dePc1 + deOff[IW-1:0];
  end

  // ---------------- memory ----------------
  logic [DW-1:0]   memAddr;
  logic [XLEN-1:0] memRead;
  assign memAddr = emAlu[DW-1:0];
  assign memRead = dmem[memAddr];

  always_ff @(posedge clk) begin
    if (rst) begin
      if (pgmWe && pgmSel) dmem[pgmAddr[DW-1:0]] <= pgmData;
    end else if (emOp == OP_SW) begin
      dmem[memAddr] <= emStore;
    end
  end

  // ---------------- pipeline registers ----------------
  assign pcPlus1 = pc + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      pc       <= '0;
      fdInstr  <= '0;
      fdPc1    <= '0;
      deOp     <= OP_NOP;
      deRa     <= '0;
      deRb     <= '0;
      deRd     <= '0;
      deValA   <= '0;
      deValB   <= '0;
      deOff    <= '0;
      dePc1    <= '0;
      emOp     <= OP_NOP;
      emRd     <= '0;
      emAlu    <= '0;
      emStore  <= '0;
      emTaken  <= 1'b0;
      emTarget <= '0;
      mwOp     <= OP_NOP;
      mwRd     <= '0;
      mwVal    <= '0;
    end else begin
      // fetch address and fetch/decode
      if (ctrl.flush) begin
        pc      <= emTarget;
        fdInstr <= '0;
        fdPc1   <= '0;
      end else if (!ctrl.stall) begin
        pc      <= pcPlus1;
        fdInstr <= imem[pc];
        fdPc1   <= pcPlus1;
      end
      // decode/execute
      if (ctrl.flush || ctrl.stall) begin
        deOp <= OP_NOP;
      end else begin
        deOp <= fdOp;
      end
      deRa   <= fdRa;
      deRb   <= fdRb;
      deRd   <= fdRd;
      deValA <= rfA;
      deValB <= rfB;
      deOff  <= fdOff;
      dePc1  <= fdPc1;
      // execute/memory
      if (ctrl.flush) begin
        emOp    <= OP_NOP;
        emTaken <= 1'b0;
      end else begin
        emOp    <= deOp;
        emTaken <= exTaken;
      end
      emRd     <= deRd;
      emAlu    <= aluRes;
      emStore  <= opB;
      emTarget <= exTarget;
      // memory/writeback
      mwOp  <= emOp;
      mwRd  <= emRd;
      mwVal <= (emOp == OP_LW) ? memRead : emAlu;
    end
  end

  // ---------------- hazard unit inputs ----------------
  assign idRegA   = fdRa;
  assign idRegB   = fdRb;
  assign idUseA   = readsA(fdOp);
  assign idUseB   = readsB(fdOp);
  assign exLoad   = (deOp == OP_LW);
  assign exDest   = deRd;
  assign exRegA   = deRa;
  assign exRegB   = deRb;
  assign memFwd   = (emOp == OP_ADD) || (emOp == OP_NAND);
  assign memDest  = emRd;
  assign wbWrites = wbWe;
  assign wbDest   = mwRd;
  assign brTaken  = emTaken;

  assign dbgMemVal = dmem[dbgMemAddr];
  assign dbgPc     = pc;

  // ---------------- assertions ----------------
  assert_pc_reset_R1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (pc == '0 && deOp == OP_NOP && emOp == OP_NOP && mwOp == OP_NOP));

  assert_flush_R5: assert property (@(posedge clk) disable iff (rst)
    ctrl.flush |=> (fdOp == OP_NOP && deOp == OP_NOP && emOp == OP_NOP && pc == $past(emTarget)));

  assert_pc_step_R6: assert property (@(posedge clk) disable iff (rst)
    (!ctrl.stall && !ctrl.flush) |=> (pc == $past(pc) + 1'b1));

  assert_stall_hold_R7: assert property (@(posedge clk) disable iff (rst)
    ctrl.stall |=> (pc == $past(pc) && deOp == OP_NOP));

  assert_stall_once_R7: assert property (@(posedge clk) disable iff (rst)
    ctrl.stall |=> !ctrl.stall);

  assert_no_load_use_R7: assert property (@(posedge clk) disable iff (rst)
    !(emOp == OP_LW && ((readsA(deOp) && emRd == deRa) || (readsB(deOp) && emRd == deRb))));

  assert_store_no_wb_R4: assert property (@(posedge clk) disable iff (rst)
    (emOp == OP_SW || emOp == OP_BEQ || emOp == OP_NOP) |=> !wbWe);

endmodule

// File: rtl/pipe_core.sv
module pipe_core
  import pipe_pkg::*;
#(
  parameter  int XLEN       = 32,
  parameter  int IMEM_DEPTH = 64,
  parameter  int DMEM_DEPTH = 64,
  localparam int IW         = $clog2(IMEM_DEPTH),
  localparam int DW         = $clog2(DMEM_DEPTH),
  localparam int PAW        = (IW > DW) ? IW : DW
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            pgmWe,
  input  logic            pgmSel,
  input  logic [PAW-1:0]  pgmAddr,
  input  logic [XLEN-1:0] pgmData,
  input  logic [RF_W-1:0] dbgRegSel,
  output logic [XLEN-1:0] dbgRegVal,
  input  logic [DW-1:0]   dbgMemAddr,
  output logic [XLEN-1:0] dbgMemVal,
  output logic [IW-1:0]   dbgPc
);

  ctrl_t           ctrl;
  logic [RF_W-1:0] idRegA, idRegB, exDest, exRegA, exRegB, memDest, wbDest;
  logic            idUseA, idUseB, exLoad, memFwd, wbWrites, brTaken;

  pipe_hazard u_hazard (
    .idRegA   (idRegA),
    .idRegB   (idRegB),
    .idUseA   (idUseA),
    .idUseB   (idUseB),
    .exLoad   (exLoad),
    .exDest   (exDest),
    .exRegA   (exRegA),
    .exRegB   (exRegB),
    .memFwd   (memFwd),
    .memDest  (memDest),
    .wbWrites (wbWrites),
    .wbDest   (wbDest),
    .brTaken  (brTaken),
    .ctrl     (ctrl)
  );

  pipe_datapath #(
    .XLEN       (XLEN),
    .IMEM_DEPTH (IMEM_DEPTH),
    .DMEM_DEPTH (DMEM_DEPTH),
    .IW         (IW),
    .DW         (DW),
    .PAW        (PAW)
  ) u_dp (
    .clk        (clk),
    .rst        (rst),
    .pgmWe      (pgmWe),
    .pgmSel     (pgmSel),
    .pgmAddr    (pgmAddr),
    .pgmData    (pgmData),
    .ctrl       (ctrl),
    .idRegA     (idRegA),
    .idRegB     (idRegB),
    .idUseA     (idUseA),
    .idUseB     (idUseB),
    .exLoad     (exLoad),
    .exDest     (exDest),
    .exRegA     (exRegA),
    .exRegB     (exRegB),
    .memFwd     (memFwd),
    .memDest    (memDest),
    .wbWrites   (wbWrites),
    .wbDest     (wbDest),
    .brTaken    (brTaken),
    .dbgRegSel  (dbgRegSel),
    .dbgRegVal  (dbgRegVal),
    .dbgMemAddr (dbgMemAddr),
    .dbgMemVal  (dbgMemVal),
    .dbgPc      (dbgPc)
  );

endmodule

// File: tb/sim_pipe_core.sv
module sim_pipe_core;

  localparam int DEPTH = 64;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        pgmWe = 1'b0;
  logic        pgmSel = 1'b0;
  logic [5:0]  pgmAddr = '0;
  logic [31:0] pgmData = '0;
  logic [2:0]  dbgRegSel = '0;
  logic [31:0] dbgRegVal;
  logic [5:0]  dbgMemAddr = '0;
  logic [31:0] dbgMemVal;
  logic [5:0]  dbgPc;

  pipe_core u0 (
    .clk(clk), .rst(rst), .pgmWe(pgmWe), .pgmSel(pgmSel), .pgmAddr(pgmAddr),
    .pgmData(pgmData), .dbgRegSel(dbgRegSel), .dbgRegVal(dbgRegVal),
    .dbgMemAddr(dbgMemAddr), .dbgMemVal(dbgMemVal), .dbgPc(dbgPc)
  );

  always #2 clk = ~clk;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  logic [31:0] prog   [DEPTH];
  logic [31:0] memInit[DEPTH];
  logic [31:0] refMem [DEPTH];
  logic [31:0] refReg [8];
  int          haltPc;
  logic [5:0]  pcSeq  [4];

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // instruction word per R2: op 26:24, regA 23:21, regB 17:15, dest 2:0, offset 14:0
  function automatic logic [31:0] enc(int op, int ra, int rb, int rd, int off);
    logic [31:0] w;
    w = (32'(op & 7) << 24) | (32'(ra & 7) << 21) | (32'(rb & 7) << 15) | 32'(off & 32'h7fff);
    w = w | 32'(rd & 7);
    return w;
  endfunction

  function automatic int sext15(logic [31:0] w);
    int v;
    v = int'(w[14:0]);
    if (w[14]) v = v - 32768;
    return v;
  endfunction

  // instruction-level reference model
  task automatic refRun();
    int pc;
    pc = 0;
    for (int r = 0; r < 8; r++) refReg[r] = '0;
    for (int a = 0; a < DEPTH; a++) refMem[a] = memInit[a];
    for (int step = 0; step < 4000; step++) begin
      logic [31:0] w, a, b;
      int op, ra, rb, rd, off, nxt;
      w  = prog[pc];
      op = int'(w[26:24]); ra = int'(w[23:21]); rb = int'(w[17:15]); rd = int'(w[2:0]);
      off = sext15(w);
      a = refReg[ra]; b = refReg[rb];
      nxt = (pc + 1) % DEPTH;
      case (op)
        1: refReg[rd] = a + b;
        2: refReg[rd] = ~(a & b);
        3: refReg[rb] = refMem[(a + 32'(off)) & 32'h3f];
        4: refMem[(a + 32'(off)) & 32'h3f] = b;
        5: if (a == b) nxt = (pc + 1 + off) & 63;
        default: ;
      endcase
      if (nxt == pc) begin haltPc = pc; break; end
      pc = nxt;
    end
  endtask

  task automatic portWrite(input bit sel, input int addr, input logic [31:0] data);
    @(negedge clk);
    pgmWe = 1'b1; pgmSel = sel; pgmAddr = 6'(addr); pgmData = data;
    @(negedge clk);
    pgmWe = 1'b0;
  endtask

  task automatic runAndCheck(input string tag, input int cycles);
    refRun();
    @(negedge clk);
    rst = 1'b1;
    for (int a = 0; a < DEPTH; a++) portWrite(1'b0, a, prog[a]);
    for (int a = 0; a < DEPTH; a++) portWrite(1'b1, a, memInit[a]);
    // R1: reset state
    check("R1 pc in reset", 32'(dbgPc), 32'd0);
    for (int r = 0; r < 8; r++) begin
      dbgRegSel = 3'(r); #0.1;
      check("R1 reg in reset", dbgRegVal, 32'd0);
    end
    @(negedge clk);
    rst = 1'b0;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      pcSeq[k] = dbgPc;
    end
    repeat (cycles) @(negedge clk);
    for (int r = 0; r < 8; r++) begin
      dbgRegSel = 3'(r); #0.1;
      check({tag, " R3/R10 register"}, dbgRegVal, refReg[r]);
    end
    for (int a = 0; a < DEPTH; a++) begin
      dbgMemAddr = 6'(a); #0.1;
      check({tag, " R4/R10 data word"}, dbgMemVal, refMem[a]);
    end
    check({tag, " R10 halted pc"}, 32'((int'(dbgPc) >= haltPc) && (int'(dbgPc) <= haltPc + 3)), 32'd1);
  endtask

  task automatic clearProg();
    for (int a = 0; a < DEPTH; a++) begin
      prog[a] = '0;
      memInit[a] = 32'($urandom) ^ (32'(a) << 8);
    end
  endtask

  task automatic checkSeq(input string req, input int p0, input int p1, input int p2, input int p3);
    check(req, 32'(pcSeq[0]), 32'(p0));
    check(req, 32'(pcSeq[1]), 32'(p1));
    check(req, 32'(pcSeq[2]), 32'(p2));
    check(req, 32'(pcSeq[3]), 32'(p3));
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20241));

    // R6/R2: forwarding chain, nearest producer, undefined opcode
    clearProg();
    prog[0] = enc(2, 0, 0, 1, 0);      // nand r1 = ~0
    prog[1] = enc(1, 1, 1, 2, 0);      // add r2 = r1+r1 (distance 1)
    prog[2] = enc(1, 2, 1, 3, 0);      // add r3 = r2+r1 (distances 1,2)
    prog[3] = enc(1, 1, 2, 1, 0);      // add r1 = r1+r2
    prog[4] = enc(1, 1, 3, 1, 0);      // add r1 = r1+r3
    prog[5] = enc(1, 1, 1, 4, 0);      // add r4 = r1+r1 (youngest r1)
    prog[6] = enc(7, 1, 2, 5, 0);      // undefined opcode, R2
    prog[7] = enc(6, 4, 4, 6, 3);      // undefined opcode, R2
    prog[8] = enc(5, 0, 0, 0, -1);     // halt
    runAndCheck("R6 chain", 60);
    checkSeq("R6 fetch advances every cycle", 1, 2, 3, 4);

    // R7: load-use stall on operand and store data
    clearProg();
    prog[0] = enc(3, 0, 1, 0, 5);      // lw r1 = mem[5]
    prog[1] = enc(1, 1, 1, 2, 0);      // add r2 = r1+r1 (stall)
    prog[2] = enc(3, 0, 3, 0, 9);      // lw r3 = mem[9]
    prog[3] = enc(4, 0, 3, 0, 20);     // sw mem[20] = r3 (stall)
    prog[4] = enc(3, 0, 4, 0, 20);     // lw r4 = mem[20] right after store
    prog[5] = enc(5, 0, 0, 0, -1);
    runAndCheck("R7 load-use", 60);
    checkSeq("R7 one-cycle stall", 1, 2, 2, 3);

    // R5: taken branch squashes three and redirects
    clearProg();
    prog[0] = enc(5, 0, 0, 0, 6);      // beq r0,r0 -> 7
    prog[1] = enc(2, 0, 0, 1, 0);      // squashed
    prog[2] = enc(2, 0, 0, 2, 0);      // squashed
    prog[3] = enc(4, 0, 0, 0, 7);      // squashed store
    prog[7] = enc(2, 0, 0, 5, 0);      // nand r5
    prog[8] = enc(5, 0, 0, 0, -1);
    runAndCheck("R5 taken", 60);
    checkSeq("R5 redirect timing", 1, 2, 3, 7);

    // R5: not-taken branch falls through
    clearProg();
    prog[0] = enc(2, 0, 0, 1, 0);      // r1 = all ones
    prog[1] = enc(5, 1, 0, 0, 3);      // beq r1,r0 not taken (uses forwarded r1)
    prog[2] = enc(1, 1, 1, 2, 0);
    prog[3] = enc(3, 2, 3, 0, 7);      // lw r3 = mem[(r2+7)]
    prog[4] = enc(5, 3, 3, 0, 1);      // beq r3,r3 taken, skips 5
    prog[5] = enc(2, 0, 0, 6, 0);      // squashed
    prog[6] = enc(5, 0, 0, 0, -1);
    runAndCheck("R5 fall-through", 60);
    checkSeq("R5 no redirect on not-taken", 1, 2, 3, 4);

    // R8: distance-three consumer reads value written back in the same cycle
    clearProg();
    prog[0] = enc(2, 0, 0, 1, 0);
    prog[1] = enc(0, 0, 0, 0, 0);
    prog[2] = enc(0, 0, 0, 0, 0);
    prog[3] = enc(1, 1, 1, 2, 0);      // reads r1 while it is written back
    prog[4] = enc(3, 0, 3, 0, 2);
    prog[5] = enc(0, 0, 0, 0, 0);
    prog[6] = enc(0, 0, 0, 0, 0);
    prog[7] = enc(1, 3, 3, 4, 0);      // loaded value via same-cycle write
    prog[8] = enc(5, 0, 0, 0, -1);
    runAndCheck("R8 same-cycle", 60);
    checkSeq("R8 no stall", 1, 2, 3, 4);

    // R9: load-port writes while running are ignored
    portWrite(1'b1, 3, 32'hdeadbeef);
    repeat (3) @(negedge clk);
    dbgMemAddr = 6'd3; #0.1;
    check("R9 port ignored when running", dbgMemVal, refMem[3]);

    // random programs for R3, R4, R5, R6, R7
    for (int t = 0; t < 25; t++) begin
      int n;
      clearProg();
      n = 8 + int'($urandom % 16);
      for (int i = 0; i < n; i++) begin
        int op, ra, rb, rd, off;
        op = 1 + int'($urandom % 5);
        ra = int'($urandom % 5); rb = int'($urandom % 5); rd = int'($urandom % 5);
        off = 0;
        if (op == 3 || op == 4) off = int'($urandom % 64) - 32;
        if (op == 5) off = int'($urandom % 32'(n - i));
        prog[i] = enc(op, ra, rb, (op <= 2) ? rd : (off & 7), off);
      end
      prog[n] = enc(5, 0, 0, 0, -1);
      runAndCheck("random R3 R4 R5 R6 R7", 4 * n + 20);
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule